// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a byte-wide flash controller. It samples a synchronous write strobe with a 17-bit address and an 8-bit data byte, and it picks out multi-write command sequences from the normal data traffic. Every command opens with a two-write unlock prefix. The byte after the prefix selects one of three things: a protected page load, an exit from identification mode, or a longer six-write sequence. The last byte of the six-write sequence clears write protection, starts a chip erase or enters identification mode.

The block keeps two flags, software write protection and identification mode. It reports its decisions as single-cycle registered pulses: an accepted byte load (with the address and data of that write), a chip-erase start, and a protection violation. While identification mode is on, it returns a manufacturer byte or a device byte depending on address bit 0. The page buffer, the cell array and the programming timer are outside this block. The timer signals the end of a page load through a timeout input.

Top module: `flash_cmd_seq`

## Requirements
- R1: The unlock prefix is data 0xAA at address 0x5555 followed by data 0x55 at address 0x2AAA. Only address bits 14..0 are compared, so bits 16..15 have no effect on matching. Matched command writes produce no load pulse.
- R2: After the prefix, 0xA0 at 0x5555 sets the protection flag and opens a page load. Every later write in that load produces a load pulse, until the timeout input ends the load.
- R3: After the prefix, 0x80 at 0x5555, then 0xAA at 0x5555, 0x55 at 0x2AAA and 0x20 at 0x5555 clear the protection flag.
- R4: The same six-write sequence ending in 0x10 produces one erase pulse, one cycle long, and no load pulse.
- R5: The six-write sequence ending in 0x60 sets the identification flag. The prefix followed by 0xF0 at 0x5555 clears it.
- R6: id_byte is 0xBF when rd_a0 is 0 and 0x07 when rd_a0 is 1 while identification mode is on, and 0x00 while it is off. It reflects its inputs one clock later.
- R7: Synchronous reset clears the protection flag, the identification flag and all pulses.
- R8: While protection is set, a write outside a protected page load produces a violation pulse and no load pulse. This holds when the write is an unmatched command write too.
- R9: A write that does not match the next expected step returns the decoder to idle. With protection clear, that write produces a load pulse carrying its own address and data.
- R10: Asserting load_timeout returns the decoder to idle from any state. A write in the same cycle is dropped.
- R11: Each pulse is high for exactly one cycle, in the cycle after the write. At most one of the three pulses is high at a time. load_addr and load_data hold the full address and data of the loaded write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| load_timeout | input | 1 | Byte-load window expired; return to idle |
| rd_a0 | input | 1 | Read address bit 0, selects identification byte |
| load_pulse | output | 1 | Accepted data byte load |
| load_addr | output | 17 | Address of the accepted load |
| load_data | output | 8 | Data of the accepted load |
| erase_pulse | output | 1 | Chip erase start |
| viol_pulse | output | 1 | Write refused by protection |
| prot_flag | output | 1 | Software write protection active |
| id_flag | output | 1 | Identification mode active |
| id_byte | output | 8 | Identification byte, zero outside identification mode |

## Verification
The decoder is driven with each complete command, with prefixes whose upper address bits are set, and with sequences broken at different steps. Broken sequences are tried once with a wrong address and once with a wrong data byte. The same stray write is applied with protection set and with protection clear, which separates a refused write from a loaded one. A timeout in the middle of a prefix and a timeout inside an open page load show that the state is dropped, not kept.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_LOAD,
    S_EXT3,
    S_EXT4,
    S_EXT5
  } seq_state_t;

  localparam logic [7:0] C_KEY1   = 8'hAA;
  localparam logic [7:0] C_KEY2   = 8'h55;
  localparam logic [7:0] C_PROT   = 8'hA0;
  localparam logic [7:0] C_EXT    = 8'h80;
  localparam logic [7:0] C_IDEXIT = 8'hF0;
  localparam logic [7:0] C_UNPROT = 8'h20;
  localparam logic [7:0] C_ERASE  = 8'h10;
  localparam logic [7:0] C_IDENT  = 8'h60;

  typedef struct packed {
    logic at_a1;
    logic at_a2;
    logic key1;
    logic key2;
    logic prot;
    logic ext;
    logic idexit;
    logic unprot;
    logic erase;
    logic ident;
  } hit_t;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 15,
  parameter int DATA_W = 8,
  parameter logic [CMP_W-1:0] ADDR_K1 = 15'h5555,
  parameter logic [CMP_W-1:0] ADDR_K2 = 15'h2AAA
) (
  input  logic [CMP_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] data,
  output hit_t              hit
);
  always_comb begin
    hit.at_a1  = (addr_lo == ADDR_K1);
    hit.at_a2  = (addr_lo == ADDR_K2);
    hit.key1   = (data == DATA_W'(C_KEY1));
    hit.key2   = (data == DATA_W'(C_KEY2));
    hit.prot   = (data == DATA_W'(C_PROT));
    hit.ext    = (data == DATA_W'(C_EXT));
    hit.idexit = (data == DATA_W'(C_IDEXIT));
    hit.unprot = (data == DATA_W'(C_UNPROT));
    hit.erase  = (data == DATA_W'(C_ERASE));
    hit.ident  = (data == DATA_W'(C_IDENT));
  end
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tmo,
  input  hit_t              hit,
  output logic              load_pulse,
  output logic [ADDR_W-1:0] load_addr,
  output logic [DATA_W-1:0] load_data,
  output logic              erase_pulse,
  output logic              viol_pulse,
  output logic              prot_q,
  output logic              id_q
);
  seq_state_t st, nxt;
  logic do_load, do_viol, do_erase, set_p, clr_p, set_id, clr_id, stray;

  always_comb begin
    nxt = st;
    do_load = 1'b0; do_viol = 1'b0; do_erase = 1'b0;
    set_p = 1'b0; clr_p = 1'b0; set_id = 1'b0; clr_id = 1'b0;
    stray = 1'b0;
    if (tmo) begin
      nxt = S_IDLE;
    end else if (wr_en) begin
      case (st)
        S_IDLE: if (hit.at_a1 && hit.key1) nxt = S_UNL1; else stray = 1'b1;
        S_UNL1: if (hit.at_a2 && hit.key2) nxt = S_UNL2; else stray = 1'b1;
        S_UNL2: begin
          if (hit.at_a1 && hit.prot) begin
            set_p = 1'b1;
            nxt = S_LOAD;
          end else if (hit.at_a1 && hit.ext) begin
            nxt = S_EXT3;
          end else if (hit.at_a1 && hit.idexit) begin
            clr_id = 1'b1;
            nxt = S_IDLE;
          end else begin
            stray = 1'b1;
          end
        end
        S_LOAD: do_load = 1'b1;
        S_EXT3: if (hit.at_a1 && hit.key1) nxt = S_EXT4; else stray = 1'b1;
        S_EXT4: if (hit.at_a2 && hit.key2) nxt = S_EXT5; else stray = 1'b1;
        S_EXT5: begin
          nxt = S_IDLE;
          if (hit.at_a1 && hit.unprot)     clr_p = 1'b1;
          else if (hit.at_a1 && hit.erase) do_erase = 1'b1;
          else if (hit.at_a1 && hit.ident) set_id = 1'b1;
          else stray = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
      if (stray) begin
        nxt = S_IDLE;
        if (prot_q) do_viol = 1'b1;
        else        do_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      load_pulse <= 1'b0;
      load_addr <= '0;
      load_data <= '0;
      erase_pulse <= 1'b0;
      viol_pulse <= 1'b0;
      prot_q <= 1'b0;
      id_q <= 1'b0;
    end else begin
      st <= nxt;
      load_pulse <= do_load;
      erase_pulse <= do_erase;
      viol_pulse <= do_viol;
      if (do_load) begin
        load_addr <= wr_addr;
        load_data <= wr_data;
      end
      if (set_p)      prot_q <= 1'b1;
      else if (clr_p) prot_q <= 1'b0;
      if (set_id)      id_q <= 1'b1;
      else if (clr_id) id_q <= 1'b0;
    end
  end
endmodule

// File: rtl/id_rom.sv
module id_rom #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_on,
  input  logic              sel,
  output logic [DATA_W-1:0] id_byte
);
  always_ff @(posedge clk) begin
    if (rst)        id_byte <= '0;
    else if (!id_on) id_byte <= '0;
    else            id_byte <= sel ? DEV_CODE : MFR_CODE;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CMP_W = 15,
  parameter logic [CMP_W-1:0] ADDR_K1 = 15'h5555,
  parameter logic [CMP_W-1:0] ADDR_K2 = 15'h2AAA,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_timeout,
  input  logic              rd_a0,
  output logic              load_pulse,
  output logic [ADDR_W-1:0] load_addr,
  output logic [DATA_W-1:0] load_data,
  output logic              erase_pulse,
  output logic              viol_pulse,
  output logic              prot_flag,
  output logic              id_flag,
  output logic [DATA_W-1:0] id_byte
);
  hit_t hit;

  cmd_match #(.CMP_W(CMP_W), .DATA_W(DATA_W), .ADDR_K1(ADDR_K1), .ADDR_K2(ADDR_K2)) u_match (
    .addr_lo(wr_addr[CMP_W-1:0]),
    .data(wr_data),
    .hit(hit)
  );

  cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmo(load_timeout), .hit(hit),
    .load_pulse(load_pulse), .load_addr(load_addr), .load_data(load_data),
    .erase_pulse(erase_pulse), .viol_pulse(viol_pulse),
    .prot_q(prot_flag), .id_q(id_flag)
  );

  id_rom #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk(clk), .rst(rst), .id_on(id_flag), .sel(rd_a0), .id_byte(id_byte)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              load_timeout,
  input logic [DATA_W-1:0] wr_data,
  input logic              load_pulse,
  input logic              erase_pulse,
  input logic              viol_pulse,
  input logic              prot_flag,
  input logic              id_flag,
  input logic [DATA_W-1:0] id_byte
);
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_pulse, erase_pulse, viol_pulse})); // R11
  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (load_pulse || erase_pulse || viol_pulse) |-> $past(wr_en && !load_timeout)); // R10
  AST_VIOL_ONLY_PROT: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> prot_flag); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!prot_flag && !id_flag && !load_pulse)); // R7
  AST_PROT_SET_CODE: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_flag) |-> $past(wr_en && wr_data == DATA_W'(8'hA0))); // R2
  AST_ERASE_CODE: assert property (@(posedge clk) disable iff (rst)
    erase_pulse |-> $past(wr_data == DATA_W'(8'h10))); // R4
  AST_ID_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !id_flag |=> (id_byte == '0)); // R6
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .load_timeout(load_timeout), .wr_data(wr_data),
  .load_pulse(load_pulse), .erase_pulse(erase_pulse), .viol_pulse(viol_pulse),
  .prot_flag(prot_flag), .id_flag(id_flag), .id_byte(id_byte)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic load_timeout = 1'b0;
  logic rd_a0 = 1'b0;
  logic load_pulse, erase_pulse, viol_pulse, prot_flag, id_flag;
  logic [16:0] load_addr;
  logic [7:0] load_data, id_byte;

  int n_chk = 0;
  int n_fail = 0;
  logic c_load, c_erase, c_viol;
  logic [16:0] c_addr;
  logic [7:0] c_data;

  always #2.5 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_timeout(load_timeout), .rd_a0(rd_a0),
    .load_pulse(load_pulse), .load_addr(load_addr), .load_data(load_data),
    .erase_pulse(erase_pulse), .viol_pulse(viol_pulse),
    .prot_flag(prot_flag), .id_flag(id_flag), .id_byte(id_byte)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    c_load = load_pulse; c_erase = erase_pulse; c_viol = viol_pulse;
    c_addr = load_addr; c_data = load_data;
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic six(input logic [7:0] last);
    unlock();
    wr(17'h05555, 8'h80);
    unlock();
    wr(17'h05555, last);
  endtask

  task automatic timeout();
    @(negedge clk); load_timeout = 1'b1;
    @(negedge clk); load_timeout = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!prot_flag, "R7 prot after reset", prot_flag, 0);
    chk(!id_flag, "R7 id after reset", id_flag, 0);
    chk(!load_pulse && !erase_pulse && !viol_pulse, "R7 pulses after reset",
        {load_pulse, erase_pulse, viol_pulse}, 0);
    chk(id_byte == 8'h00, "R6 id_byte off", id_byte, 0);
  endtask

  task automatic t_plain_load();
    wr(17'h11234, 8'h5A);
    chk(c_load, "R9 plain write loads", c_load, 1);
    chk(c_addr == 17'h11234 && c_data == 8'h5A, "R11 load addr/data", {c_addr, c_data}, {17'h11234, 8'h5A});
    @(negedge clk);
    chk(!load_pulse, "R11 pulse one cycle", load_pulse, 0);
  endtask

  task automatic t_protect_upper_bits();
    wr(17'h1D555, 8'hAA);
    chk(!c_load && !c_viol, "R1 key1 with upper bits consumed", {c_load, c_viol}, 0);
    wr(17'h1AAAA, 8'h55);
    chk(!c_load && !c_viol, "R1 key2 with upper bits consumed", {c_load, c_viol}, 0);
    wr(17'h15555, 8'hA0);
    chk(!c_load, "R1 command write not loaded", c_load, 0);
    chk(prot_flag, "R2 protection set", prot_flag, 1);
    wr(17'h00400, 8'h11);
    chk(c_load && c_addr == 17'h00400 && c_data == 8'h11, "R2 protected load 1", {c_load, c_data}, {1'b1, 8'h11});
    wr(17'h05555, 8'hAA);
    chk(c_load && c_data == 8'hAA, "R2 protected load of key byte", {c_load, c_data}, {1'b1, 8'hAA});
  endtask

  task automatic t_timeout_then_viol();
    timeout();
    wr(17'h00402, 8'h33);
    chk(c_viol && !c_load, "R10 R8 write after load closed refused", {c_viol, c_load}, 2'b10);
    unlock();
    wr(17'h02AAA, 8'h77);
    chk(c_viol && !c_load, "R8 unmatched command write refused", {c_viol, c_load}, 2'b10);
  endtask

  task automatic t_unprotect();
    six(8'h20);
    chk(!prot_flag, "R3 protection cleared", prot_flag, 0);
    chk(!c_load && !c_viol, "R3 no pulse on final byte", {c_load, c_viol}, 0);
    wr(17'h00010, 8'h44);
    chk(c_load, "R3 plain write loads again", c_load, 1);
  endtask

  task automatic t_erase();
    six(8'h10);
    chk(c_erase && !c_load, "R4 erase pulse", {c_erase, c_load}, 2'b10);
    @(negedge clk);
    chk(!erase_pulse, "R4 erase one cycle", erase_pulse, 0);
  endtask

  task automatic t_ident();
    six(8'h60);
    chk(id_flag, "R5 id mode entered", id_flag, 1);
    rd_a0 = 1'b0;
    @(negedge clk);
    chk(id_byte == 8'hBF, "R6 manufacturer byte", id_byte, 8'hBF);
    rd_a0 = 1'b1;
    @(negedge clk);
    chk(id_byte == 8'h07, "R6 device byte", id_byte, 8'h07);
    unlock();
    wr(17'h05555, 8'hF0);
    chk(!id_flag, "R5 id mode left", id_flag, 0);
    @(negedge clk);
    chk(id_byte == 8'h00, "R6 zero after exit", id_byte, 0);
    rd_a0 = 1'b0;
  endtask

  task automatic t_mismatch();
    wr(17'h05555, 8'hAA);
    wr(17'h05555, 8'h55);
    chk(c_load && c_addr == 17'h05555 && c_data == 8'h55, "R9 wrong address loaded", {c_load, c_data}, {1'b1, 8'h55});
    wr(17'h02AAA, 8'h55);
    chk(c_load && c_data == 8'h55, "R9 back at idle", {c_load, c_data}, {1'b1, 8'h55});
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h66);
    chk(c_load && c_data == 8'h66, "R9 wrong data loaded", {c_load, c_data}, {1'b1, 8'h66});
  endtask

  task automatic t_timeout_mid();
    unlock();
    timeout();
    wr(17'h05555, 8'hA0);
    chk(c_load && !prot_flag, "R10 prefix dropped by timeout", {c_load, prot_flag}, 2'b10);
  endtask

  task automatic t_reset_clears();
    six(8'h60);
    unlock();
    wr(17'h05555, 8'hA0);
    chk(prot_flag && id_flag, "R7 both flags set before reset", {prot_flag, id_flag}, 2'b11);
    timeout();
    do_reset();
    chk(!prot_flag && !id_flag, "R7 flags cleared by reset", {prot_flag, id_flag}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_load();
    t_protect_upper_bits();
    t_timeout_then_viol();
    t_unprotect();
    t_erase();
    t_ident();
    t_mismatch();
    t_timeout_mid();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule